// File: doc/BRIEF.md
# Timer Gate and Speaker Control Port

This block is an 8-bit system-control register that sits beside timer channel 2. Software writes to it to drive the gate input of channel 2 and a speaker-enable line. When software reads it, it gets back those two bits together with a free-running refresh toggle and the live output level of channel 2. The timer channel itself is outside this block. Its mode number and output level come in on input ports, and the block drives the gate level and a restart pulse back to it.

A write that raises the gate from 0 to 1 emits a one-cycle restart pulse, so that the gate-triggered counting modes begin a fresh count. Modes 0 and 4 ignore gate rising edges and get no pulse. The refresh toggle comes from a parameterized divider of the system clock. Bit positions that carry error-check or interrupt status in a full system controller always read as zero here.

Top module: `sysctl_port`

## Requirements
- R1: A cycle with `wr_en_i` high loads `wr_data_i[0]` into the gate and `wr_data_i[1]` into the speaker enable. `ch2_gate_o` and `spk_en_o` show the new values from the clock edge of that write onward. With `wr_en_i` low, neither output changes.
- R2: Reset (active-low `rst_n`) clears the gate, the speaker enable and the restart pulse to 0.
- R3: `rd_data_o` is combinational and reflects the current state in the same cycle. Bit 0 is the gate, bit 1 is the speaker enable, and bit 5 is `ch2_out_i`.
- R4: Bits 2, 3, 6 and 7 of `rd_data_o` are always 0, whatever value was written.
- R5: Bit 4 of `rd_data_o` is the refresh toggle. It is 0 out of reset and inverts once every `REFRESH_DIV` clock edges after reset is released.
- R6: `ch2_restart_o` is high for exactly one cycle, the cycle that follows the write edge, when a write takes the gate from 0 to 1 while `ch2_mode_i` (the channel's mode number, 0 to 7) is 1, 2, 3, 5, 6 or 7. Modes 6 and 7 count as aliases of 2 and 3.
- R7: No restart pulse occurs when the mode is 0 or 4, when a write leaves the gate at 1, or when a write lowers the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (combinational) |
| ch2_mode_i | input | 3 | Counting mode of channel 2 |
| ch2_out_i | input | 1 | Output level of channel 2 |
| ch2_gate_o | output | 1 | Gate level to channel 2 |
| spk_en_o | output | 1 | Speaker enable |
| ch2_restart_o | output | 1 | One-cycle restart pulse to channel 2 |

## Verification
The bench builds the block with `REFRESH_DIV` = 4. This keeps the refresh toggle short enough that every toggle edge over many periods can be compared against a count kept in the bench. The bench sweeps all eight mode numbers against every pairing of old and new gate values, and both speaker-enable values against both channel output levels. It writes all-ones and all-zeros patterns to show that the reserved bits stay zero.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned MODE_W     = 3;
   localparam int unsigned BIT_GATE   = 0;
   localparam int unsigned BIT_SPK    = 1;
   localparam int unsigned BIT_REFR   = 4;
   localparam int unsigned BIT_OUT    = 5;

   // Gate-triggered modes: 1, 2, 3, 5 (6 and 7 alias 2 and 3).
   function automatic logic gate_retriggers(input logic [MODE_W-1:0] mode);
      return !(mode == 3'd0 || mode == 3'd4);
   endfunction
endpackage

// File: rtl/sysctl_refresh_div.sv
module sysctl_refresh_div #(
   parameter int unsigned REFRESH_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic toggle_o
);
   localparam int unsigned CNT_W = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_DIV - 1);

   initial begin
      if (REFRESH_DIV < 2) $error("REFRESH_DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         tog_q <= ~tog_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign toggle_o = tog_q;

   // R5: the toggle only moves when the divider wraps
   assert_refresh_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_q != $past(tog_q)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/sysctl_gate_ctl.sv
module sysctl_gate_ctl
   import sysctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              gate_d_i,
   input  logic              spk_d_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              gate_o,
   output logic              spk_o,
   output logic              restart_o
);
   logic gate_q, spk_q, restart_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         spk_q     <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         restart_q <= wr_en_i && gate_d_i && !gate_q && gate_retriggers(mode_i);
         if (wr_en_i) begin
            gate_q <= gate_d_i;
            spk_q  <= spk_d_i;
         end
      end
   end

   assign gate_o    = gate_q;
   assign spk_o     = spk_q;
   assign restart_o = restart_q;

   assert_hold_without_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en_i) |-> ($stable(gate_q) && $stable(spk_q)));
   assert_restart_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |-> (gate_q && !$past(gate_q)));
   assert_restart_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |=> !restart_q);
   assert_no_restart_mode04_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |-> ($past(mode_i) != 3'd0 && $past(mode_i) != 3'd4));
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
   import sysctl_pkg::*;
(
   input  logic             gate_i,
   input  logic             spk_i,
   input  logic             refr_i,
   input  logic             out_i,
   output logic [REG_W-1:0] rd_o
);
   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (b == BIT_GATE) begin : g_gate
         assign rd_o[b] = gate_i;
      end else if (b == BIT_SPK) begin : g_spk
         assign rd_o[b] = spk_i;
      end else if (b == BIT_REFR) begin : g_refr
         assign rd_o[b] = refr_i;
      end else if (b == BIT_OUT) begin : g_out
         assign rd_o[b] = out_i;
      end else begin : g_zero
         assign rd_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
   import sysctl_pkg::*;
#(
   parameter int unsigned REFRESH_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic [MODE_W-1:0] ch2_mode_i,
   input  logic             ch2_out_i,
   output logic             ch2_gate_o,
   output logic             spk_en_o,
   output logic             ch2_restart_o
);
   logic refr;

   sysctl_refresh_div #(.REFRESH_DIV(REFRESH_DIV)) i_div (
      .clk(clk), .rst_n(rst_n), .toggle_o(refr)
   );

   sysctl_gate_ctl i_gate (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
      .gate_d_i(wr_data_i[BIT_GATE]), .spk_d_i(wr_data_i[BIT_SPK]),
      .mode_i(ch2_mode_i), .gate_o(ch2_gate_o), .spk_o(spk_en_o),
      .restart_o(ch2_restart_o)
   );

   sysctl_rd_mux i_mux (
      .gate_i(ch2_gate_o), .spk_i(spk_en_o), .refr_i(refr),
      .out_i(ch2_out_i), .rd_o(rd_data_o)
   );

   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o & 8'hCC) == 8'h00);
   assert_out_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[BIT_OUT] == ch2_out_i);
endmodule

// File: tb/test_sysctl_port.sv
module test_sysctl_port;
   localparam int unsigned DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [2:0] mode = 3'd0;
   logic       ch2_out = 1'b0;
   logic       gate, spk, restart;

   int n_chk = 0;
   int n_bad = 0;
   int edges = 0;

   always #4 clk = ~clk;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   sysctl_port #(.REFRESH_DIV(DIV)) i_sysctl_port (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .ch2_mode_i(mode), .ch2_out_i(ch2_out),
      .ch2_gate_o(gate), .spk_en_o(spk), .ch2_restart_o(restart)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at negedge, edge takes the write, back at next negedge
   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R2 gate", gate, 0);
      chk("R2 spk", spk, 0);
      chk("R2 restart", restart, 0);
      rst_n = 1'b1;

      // R5: refresh toggle period
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         chk("R5 refresh", rd_data[4], (edges / DIV) % 2);
      end

      // R1/R3/R4: write patterns and read-back
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 2; o++) begin
            ch2_out = o[0];
            wr(8'hFC | 8'(s));
            chk("R1 gate", gate, s & 1);
            chk("R1 spk", spk, (s >> 1) & 1);
            chk("R3 rd gate", rd_data[0], s & 1);
            chk("R3 rd spk", rd_data[1], (s >> 1) & 1);
            chk("R3 rd out", rd_data[5], o);
            chk("R4 reserved", rd_data & 8'hCC, 0);
         end
      end
      wr(8'h03);
      @(negedge clk);
      chk("R1 hold gate", gate, 1);
      chk("R1 hold spk", spk, 1);
      chk("R4 reserved zero", rd_data & 8'hCC, 0);

      // R6/R7: restart sweep
      for (int m = 0; m < 8; m++) begin
         for (int p = 0; p < 2; p++) begin
            for (int nw = 0; nw < 2; nw++) begin
               mode = 3'(m);
               wr(8'(p));
               @(negedge clk);
               chk("R6 pulse single", restart, 0);
               wr(8'(nw) | 8'h02);
               if (p == 0 && nw == 1 && m != 0 && m != 4)
                  chk("R6 restart", restart, 1);
               else
                  chk("R7 no restart", restart, 0);
               chk("R1 gate sweep", gate, nw);
               @(negedge clk);
               chk("R6 one cycle", restart, 0);
            end
         end
      end

      // R2: reset mid-run
      wr(8'h03);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R2 reset gate", gate, 0);
      chk("R2 reset spk", spk, 0);
      chk("R2 reset refresh", rd_data[4], 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule